// File: doc/BRIEF.md
# Oversampled Pixel Stream Frame Assembler

This block turns a serial pixel stream from an 8×8 image sensor into a stored frame. Each pixel lasts one pixel-clock period. Within that period the sensor output is sampled eight times, and each sample arrives with a strobe. The first half of those samples is disturbed by switching transients when the sensor moves to a new row, so it is dropped. The retained half is summed and rounded to a 2-bit pixel value. That value is written into a 64-entry frame store at its row and column position.

Two sources can feed the block. The first is a converter path with 2-bit samples. The second is a comparator path that gives 1-bit samples. A separate pixel-boundary marker closes each pixel. A frame-start marker restarts assembly at row 0, column 0. One of the sensor paths scans its columns in the opposite order, so a column-reversal input mirrors the column index on write. When all 64 pixels of a frame have been stored, a frame-valid flag is raised. A host then reads the frame at random through a registered read port.

Top module: `pixel_frame_asm`

## Requirements
- R1: Within a pixel, samples at positions 0 to 3 (counting strobes from the previous boundary or frame start) have no effect on the stored value.
- R2: In converter mode (`dig_path_i`=0) the stored value is (S+2)>>2. S is the sum of the 2-bit samples at positions 4 to 7, so the result ranges from 0 to 3.
- R3: In comparator mode (`dig_path_i`=1) only `smp_data_i[0]` is used. The stored value is 1 when at least two of the four retained bits are 1, and 0 otherwise.
- R4: Strobes after the eighth sample of a pixel, up to and including its boundary, are ignored.
- R5: A boundary that arrives after fewer than eight samples raises `short_pix_o` for one cycle, starting at the clock edge that takes the boundary. The value of such a pixel uses only the retained positions it received, and missing samples count as 0.
- R6: The k-th pixel of a frame (k from 0) goes to row k/8 and stream column k%8. Its read address is row*8 + column.
- R7: With `col_rev_i`=1, the pixel at stream column c is stored at column 7−c.
- R8: `frame_valid_o` rises at the edge that writes the 64th pixel. Pixels that arrive while it is high are not stored.
- R9: `frame_start_i` clears `frame_valid_o` at the next edge, restarts at row 0, column 0, and discards any partial pixel. A strobe or boundary in the same cycle as the frame start is also discarded.
- R10: `rd_data_o` shows the entry at `rd_addr_i` one clock edge after the address is presented.
- R11: After reset, `frame_valid_o` and `short_pix_o` are 0 and every frame-store entry reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_valid_i | input | 1 | Sample strobe |
| smp_data_i | input | 2 | Sample value (bit 0 only in comparator mode) |
| dig_path_i | input | 1 | 1 selects comparator (1-bit) samples |
| col_rev_i | input | 1 | Mirror the column index on write |
| pix_end_i | input | 1 | Pixel boundary; a strobe in the same cycle belongs to this pixel |
| frame_start_i | input | 1 | Restart frame assembly |
| rd_addr_i | input | 6 | Read address, row in the upper three bits |
| rd_data_o | output | 2 | Registered read data |
| frame_valid_o | output | 1 | Full frame stored |
| short_pix_o | output | 1 | Last closed pixel had fewer than eight samples |

## Verification
A pixel is committed at the edge that takes its boundary. `short_pix_o` and `frame_valid_o` therefore change at that edge. Read data appears one edge after the address. The bench drives every input at the falling edge. It samples the flags at the falling edge right after the boundary cycle, and it samples read data at the falling edge that follows the one where the address was set. Stored values are checked only after the frame is complete. They are read back in the order in which a queue of expected address and value pairs was filled.

// File: rtl/pfa_pkg.sv
package pfa_pkg;
  localparam int SMP_W = 2;
  localparam int PIX_W = 2;
endpackage

// File: rtl/pfa_sample_acc.sv
module pfa_sample_acc
  import pfa_pkg::*;
#(
  parameter int SPP  = 8,
  parameter int SKIP = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             smp_valid_i,
  input  logic [SMP_W-1:0] smp_data_i,
  input  logic             dig_path_i,
  input  logic             pix_end_i,
  input  logic             frame_start_i,
  output logic             commit_o,
  output logic [PIX_W-1:0] val_o,
  output logic             short_o
);
  localparam int KEEP  = SPP - SKIP;
  localparam int CNT_W = $clog2(SPP + 1);
  localparam int SUM_W = $clog2(KEEP * ((1 << SMP_W) - 1) + 1) + 1;
  localparam int SH    = $clog2(KEEP);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [SUM_W-1:0] sum_q, sum_d, rnd;
  logic [SMP_W-1:0] smp;
  logic             keep_now;

  assign smp      = dig_path_i ? SMP_W'(smp_data_i[0]) : smp_data_i;
  assign keep_now = smp_valid_i && (cnt_q >= CNT_W'(SKIP)) && (cnt_q < CNT_W'(SPP));
  assign sum_d    = sum_q + (keep_now ? SUM_W'(smp) : '0);
  assign cnt_d    = cnt_q + CNT_W'(smp_valid_i && (cnt_q < CNT_W'(SPP)));
  assign rnd      = sum_d + SUM_W'(KEEP / 2);

  assign commit_o = pix_end_i && !frame_start_i;
  assign val_o    = PIX_W'(rnd >> SH);
  assign short_o  = cnt_d < CNT_W'(SPP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sum_q <= '0;
    end else if (frame_start_i || pix_end_i) begin
      cnt_q <= '0;
      sum_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      sum_q <= sum_d;
    end
  end

  // counter saturates at one full pixel
  p_cnt_sat_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(SPP));
  // nothing accumulated while still in the settling window
  p_skip_empty_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q <= CNT_W'(SKIP)) |-> (sum_q == '0));
  p_sum_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sum_q <= SUM_W'(KEEP * ((1 << SMP_W) - 1)));
  p_restart_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_start_i || pix_end_i) |=> (cnt_q == '0));
endmodule

// File: rtl/pfa_frame_wr.sv
module pfa_frame_wr #(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  localparam int ROW_W = $clog2(ROWS),
  localparam int COL_W = $clog2(COLS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   commit_i,
  input  logic                   col_rev_i,
  input  logic                   frame_start_i,
  output logic                   we_o,
  output logic [ROW_W+COL_W-1:0] waddr_o,
  output logic                   frame_valid_o
);
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q, col_w;
  logic             fv_q, last_col, last_pix;

  assign last_col = col_q == COL_W'(COLS - 1);
  assign last_pix = last_col && (row_q == ROW_W'(ROWS - 1));
  assign col_w    = col_rev_i ? (COL_W'(COLS - 1) - col_q) : col_q;

  assign we_o          = commit_i && !fv_q;
  assign waddr_o       = {row_q, col_w};
  assign frame_valid_o = fv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q <= '0;
      col_q <= '0;
      fv_q  <= 1'b0;
    end else if (frame_start_i) begin
      row_q <= '0;
      col_q <= '0;
      fv_q  <= 1'b0;
    end else if (we_o) begin
      col_q <= last_col ? '0 : col_q + 1'b1;
      if (last_col) row_q <= last_pix ? '0 : row_q + 1'b1;
      if (last_pix) fv_q <= 1'b1;
    end
  end

  p_fv_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |=> !frame_valid_o);
  p_fv_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_valid_o && !frame_start_i) |=> frame_valid_o);
  // complete frame leaves the position wrapped to the origin
  p_fv_origin_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_o |-> (row_q == '0 && col_q == '0));
  p_pos_frozen_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_valid_o && !frame_start_i) |=> $stable(waddr_o) || $changed(col_rev_i));
endmodule

// File: rtl/pfa_frame_mem.sv
module pfa_frame_mem #(
  parameter int DEPTH = 64,
  parameter int DW    = 2,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/pixel_frame_asm.sv
module pixel_frame_asm
  import pfa_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  parameter int SPP  = 8,
  parameter int SKIP = 4,
  localparam int AW  = $clog2(ROWS * COLS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             smp_valid_i,
  input  logic [SMP_W-1:0] smp_data_i,
  input  logic             dig_path_i,
  input  logic             col_rev_i,
  input  logic             pix_end_i,
  input  logic             frame_start_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [PIX_W-1:0] rd_data_o,
  output logic             frame_valid_o,
  output logic             short_pix_o
);
  logic             commit, short_c, we;
  logic [PIX_W-1:0] val;
  logic [AW-1:0]    waddr;
  logic             short_q;

  pfa_sample_acc #(.SPP(SPP), .SKIP(SKIP)) u_acc (
    .clk_i, .rst_ni, .smp_valid_i, .smp_data_i, .dig_path_i, .pix_end_i,
    .frame_start_i, .commit_o(commit), .val_o(val), .short_o(short_c)
  );

  pfa_frame_wr #(.ROWS(ROWS), .COLS(COLS)) u_wr (
    .clk_i, .rst_ni, .commit_i(commit), .col_rev_i, .frame_start_i,
    .we_o(we), .waddr_o(waddr), .frame_valid_o
  );

  pfa_frame_mem #(.DEPTH(ROWS * COLS), .DW(PIX_W)) u_mem (
    .clk_i, .rst_ni, .we_i(we), .waddr_i(waddr), .wdata_i(val),
    .raddr_i(rd_addr_i), .rdata_o(rd_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) short_q <= 1'b0;
    else         short_q <= commit && short_c;
  end
  assign short_pix_o = short_q;

  p_short_src_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    short_pix_o |-> $past(pix_end_i && !frame_start_i));
endmodule

// File: tb/pixel_frame_asm_tb.sv
module pixel_frame_asm_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       smp_valid = 1'b0, dig = 1'b0, mir = 1'b0, pix_end = 1'b0, fs = 1'b0;
  logic [1:0] smp_data = '0;
  logic [5:0] rd_addr = '0;
  logic [1:0] rd_data;
  logic       fv, short_pix;

  int n_tests = 0;
  int n_fail  = 0;

  typedef struct packed { logic [5:0] addr; logic [1:0] val; } exp_t;
  exp_t sb_q[$];

  always #2 clk = ~clk;

  pixel_frame_asm dut_i (
    .clk_i(clk), .rst_ni(rst_n), .smp_valid_i(smp_valid), .smp_data_i(smp_data),
    .dig_path_i(dig), .col_rev_i(mir), .pix_end_i(pix_end), .frame_start_i(fs),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .frame_valid_o(fv), .short_pix_o(short_pix)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [1:0] smp_of(input int k, input int i, input int seed);
    int x;
    x = k * 7 + i * 3 + (k >> 2) + seed;
    if (k == 30) return 2'd3;
    if (k == 31) return (i < 4) ? 2'd3 : 2'd0;
    return x[1:0];
  endfunction

  function automatic int n_of(input int k);
    case (k)
      5:  return 6;
      9:  return 3;
      13: return 10;
      20: return 4;
      default: return 8;
    endcase
  endfunction

  // driver: sends one pixel and pushes the expected store entry
  task automatic send_pixel(input int k, input int seed, input int n, input bit push);
    int sum = 0;
    logic [1:0] v;
    logic [2:0] c;
    for (int i = 0; i < n; i++) begin
      v = smp_of(k, i, seed);
      @(negedge clk);
      smp_valid = 1'b1; smp_data = v; pix_end = (i == n - 1);
      if (i >= 4 && i < 8) sum += dig ? int'(v[0]) : int'(v);
    end
    @(negedge clk);
    smp_valid = 1'b0; pix_end = 1'b0; smp_data = '0;
    chk(short_pix == (n < 8), (n < 8) ? "R5 short flag" : "R4 no short flag",
        int'(short_pix), int'(n < 8));
    if (push) begin
      c = mir ? 3'(7 - (k % 8)) : 3'(k % 8);
      sb_q.push_back('{addr: {3'(k / 8), c}, val: 2'((sum + 2) >> 2)});
    end
  endtask

  // monitor: pops expected entries and compares registered read data
  task automatic check_frame(input string req);
    exp_t e;
    while (sb_q.size() > 0) begin
      e = sb_q.pop_front();
      @(negedge clk); rd_addr = e.addr;
      @(negedge clk);
      chk(rd_data == e.val, req, int'(rd_data), int'(e.val));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(fv == 1'b0, "R11 frame_valid after reset", int'(fv), 0);
    chk(short_pix == 1'b0, "R11 short after reset", int'(short_pix), 0);
    rd_addr = 6'd37;
    @(negedge clk);
    chk(rd_data == 2'd0, "R11 store cleared", int'(rd_data), 0);

    // frame A: converter path, no mirror; covers R1 R2 R4 R5 R6 R10
    dig = 1'b0; mir = 1'b0;
    for (int k = 0; k < 64; k++) begin
      send_pixel(k, 0, n_of(k), 1'b1);
      if (k == 62) chk(fv == 1'b0, "R8 not valid before last pixel", int'(fv), 0);
      if (k == 63) chk(fv == 1'b1, "R8 valid after 64th pixel", int'(fv), 1);
    end
    check_frame("R2 R6 R10 frame A value");

    // extra pixel while full must not land anywhere
    send_pixel(0, 2, 8, 1'b0);
    chk(fv == 1'b1, "R8 valid holds", int'(fv), 1);
    sb_q.push_back('{addr: 6'd0, val: 2'((int'(smp_of(0,4,0)) + int'(smp_of(0,5,0))
                     + int'(smp_of(0,6,0)) + int'(smp_of(0,7,0)) + 2) >> 2)});
    check_frame("R8 store unchanged when full");

    // frame start with a simultaneous strobe and boundary
    @(negedge clk); fs = 1'b1; smp_valid = 1'b1; pix_end = 1'b1; smp_data = 2'd3;
    @(negedge clk); fs = 1'b0; smp_valid = 1'b0; pix_end = 1'b0; smp_data = '0;
    chk(fv == 1'b0, "R9 frame_valid cleared", int'(fv), 0);
    chk(short_pix == 1'b0, "R9 boundary with frame start ignored", int'(short_pix), 0);
    // partial pixel then another frame start: partial must be discarded
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); smp_valid = 1'b1; smp_data = 2'd3;
    end
    @(negedge clk); smp_valid = 1'b0; fs = 1'b1;
    @(negedge clk); fs = 1'b0;

    // frame B: comparator path, mirrored columns; covers R3 R7 R9
    dig = 1'b1; mir = 1'b1;
    for (int k = 0; k < 64; k++) send_pixel(k, 1, (k == 11) ? 7 : 8, 1'b1);
    chk(fv == 1'b1, "R8 valid after frame B", int'(fv), 1);
    check_frame("R3 R7 R9 frame B value");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule